// File: doc/BRIEF.md
# SDRAM Bank Address Decoder

This block sits between the system bus and an SDRAM controller. It works out which memory bank, if any, an incoming bus address belongs to. Each of the banks is described by one 32-bit configuration word that the register file supplies. The word carries three fields: the bank's start address, a size code and a valid flag. A single controller-enable input switches all decoding on or off together.

Every cycle in which the address qualifier is high, the block compares the address against every bank in parallel. One cycle later it reports the result on its outputs:

- which bank claimed the address, as a one-hot vector and as an index;
- the offset of the address inside that bank;
- a miss flag if no usable bank claimed it.

The configuration and the enable are sampled on the same edge as the address. A change to a bank therefore takes effect for the next request after it.

Top module: `sdram_bank_decoder`

## Requirements
- R1: A bank's start address is bits 31:23 of its configuration word followed by 23 zero bits, so bank starts fall on 8 MiB boundaries.
- R2: Bits 19:17 of the configuration word hold a size code c, and the bank spans 4 MiB << c bytes (4 MiB for code 0 up to 256 MiB for code 6).
- R3: A bank whose size code is 7 never claims any address.
- R4: A bank claims addresses only while bit 0 of its word is 1 and `ctrl_en` is 1; with `ctrl_en` at 0 every request misses.
- R5: A usable bank claims address a exactly when start <= a < start + span. The sum is taken without wrapping, so a bank near the top of the 4 GiB space never claims low addresses.
- R6: On a hit, `dec_offset` equals the address minus the winning bank's start; on a miss it is 0.
- R7: When several banks claim an address, the lowest-numbered one wins. `dec_onehot` then has exactly that bank's bit set, and `dec_bank` holds its number.
- R8: For each accepted request exactly one of `dec_hit` and `dec_miss` is 1. `dec_miss` is 1 when no bank claims the address, and then `dec_onehot` is 0.
- R9: Results appear one clock after `addr_vld` is sampled high. `dec_vld` mirrors `addr_vld` with one cycle of delay, and while it is 0, `dec_hit`, `dec_miss` and `dec_onehot` are all 0.
- R10: Configuration bits that are 0 in the writable mask 0xFFDEE001 have no effect on any decode result.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller-wide decode enable |
| bank_cfg | input | NUM_BANKS*WORD_W | Bank configuration words, bank 0 in the low word |
| addr_vld | input | 1 | Address qualifier |
| addr | input | WORD_W | Bus address to decode |
| dec_vld | output | 1 | Result valid, one cycle after addr_vld |
| dec_hit | output | 1 | Some bank claimed the address |
| dec_miss | output | 1 | No bank claimed the address |
| dec_bank | output | IDX_W | Number of the winning bank |
| dec_onehot | output | NUM_BANKS | One-hot winning bank |
| dec_offset | output | WORD_W | Address minus the winning bank's start |

## Verification
The assertions assume that `addr_vld`, `ctrl_en` and `bank_cfg` carry known values at every sampling edge after reset. The per-bank properties relate the configuration seen at the request edge to the result one cycle later, so they need no stability assumption about later cycles. The stimulus changes inputs only at the falling edge and holds them through the next rising edge. It sweeps the whole 32-bit address space in 2 MiB steps with varying low bits. It also hits the cycle before, at and after each bank boundary, across configurations that cover overlap, a reserved size code, a bank at the top of the space, invalid banks, the global enable off, and junk in the masked-off bits.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
   localparam int unsigned DEF_WORD_W    = 32;
   localparam int unsigned DEF_BASE_LSB  = 23;
   localparam int unsigned DEF_SIZE_LSB  = 17;
   localparam int unsigned DEF_SIZE_W    = 3;
   localparam int unsigned DEF_MIN_LOG2  = 22;
   localparam logic [31:0] DEF_CFG_MASK  = 32'hFFDE_E001;

   // width of an index for n items, never zero
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // highest size code, kept as a reserved value
   function automatic int unsigned reserved_code(input int unsigned w);
      return (1 << w) - 1;
   endfunction
endpackage

// File: rtl/sdram_bank_match.sv
module sdram_bank_match
   import sdram_dec_pkg::*;
#(
   parameter int unsigned WORD_W   = DEF_WORD_W,
   parameter int unsigned BASE_LSB = DEF_BASE_LSB,
   parameter int unsigned SIZE_LSB = DEF_SIZE_LSB,
   parameter int unsigned SIZE_W   = DEF_SIZE_W,
   parameter int unsigned MIN_LOG2 = DEF_MIN_LOG2,
   parameter logic [WORD_W-1:0] CFG_MASK = WORD_W'(DEF_CFG_MASK)
) (
   input  logic              en,
   input  logic [WORD_W-1:0] cfg,
   input  logic [WORD_W-1:0] addr,
   output logic              match,
   output logic [WORD_W-1:0] offset
);
   localparam int unsigned SUM_W = WORD_W + 1;
   localparam int unsigned RSV   = reserved_code(SIZE_W);

   logic [WORD_W-1:0] kept;
   logic [WORD_W-1:0] start;
   logic [SIZE_W-1:0] code;
   logic [SUM_W-1:0]  limit;
   logic              usable;
   logic              above;
   logic              below;

   always_comb begin
      kept   = cfg & CFG_MASK;
      start  = {kept[WORD_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
      code   = kept[SIZE_LSB +: SIZE_W];
      limit  = {1'b0, start} + (SUM_W'(1) << (MIN_LOG2 + 32'(code)));
      usable = en && kept[0] && (32'(code) != RSV);
      above  = addr >= start;
      below  = {1'b0, addr} < limit;
      match  = usable && above && below;
      offset = addr - start;
   end
endmodule

// File: rtl/sdram_bank_pick.sv
module sdram_bank_pick
   import sdram_dec_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned WORD_W    = DEF_WORD_W,
   localparam int unsigned IDX_W    = idx_width(NUM_BANKS)
) (
   input  logic [NUM_BANKS-1:0]        match,
   input  logic [NUM_BANKS*WORD_W-1:0] offsets,
   output logic                        any,
   output logic [IDX_W-1:0]            idx,
   output logic [NUM_BANKS-1:0]        onehot,
   output logic [WORD_W-1:0]           offset
);
   always_comb begin
      any    = |match;
      idx    = '0;
      onehot = '0;
      offset = '0;
      // walk from the top so the lowest matching bank is written last
      for (int b = NUM_BANKS - 1; b >= 0; b--) begin
         if (match[b]) begin
            idx    = IDX_W'(b);
            onehot = NUM_BANKS'(1) << b;
            offset = offsets[b*WORD_W +: WORD_W];
         end
      end
   end
endmodule

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder
   import sdram_dec_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned WORD_W    = DEF_WORD_W,
   parameter int unsigned BASE_LSB  = DEF_BASE_LSB,
   parameter int unsigned SIZE_LSB  = DEF_SIZE_LSB,
   parameter int unsigned SIZE_W    = DEF_SIZE_W,
   parameter int unsigned MIN_LOG2  = DEF_MIN_LOG2,
   parameter logic [WORD_W-1:0] CFG_MASK = WORD_W'(DEF_CFG_MASK),
   localparam int unsigned IDX_W    = idx_width(NUM_BANKS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ctrl_en,
   input  logic [NUM_BANKS*WORD_W-1:0] bank_cfg,
   input  logic                        addr_vld,
   input  logic [WORD_W-1:0]           addr,
   output logic                        dec_vld,
   output logic                        dec_hit,
   output logic                        dec_miss,
   output logic [IDX_W-1:0]            dec_bank,
   output logic [NUM_BANKS-1:0]        dec_onehot,
   output logic [WORD_W-1:0]           dec_offset
);
   localparam int unsigned MAX_SPAN_LOG2 = MIN_LOG2 + reserved_code(SIZE_W) - 1;

   generate
      if (NUM_BANKS < 1)
         $error("sdram_bank_decoder: NUM_BANKS must be at least 1");
      if (SIZE_LSB < 1 || SIZE_LSB + SIZE_W > BASE_LSB)
         $error("sdram_bank_decoder: size field must lie between bit 0 and the base field");
      if (BASE_LSB >= WORD_W)
         $error("sdram_bank_decoder: base field must fit in the word");
      if (MAX_SPAN_LOG2 > WORD_W)
         $error("sdram_bank_decoder: largest bank exceeds the address space");
   endgenerate

   logic [NUM_BANKS-1:0]        match;
   logic [NUM_BANKS*WORD_W-1:0] offsets;
   logic                        any;
   logic [IDX_W-1:0]            pick_idx;
   logic [NUM_BANKS-1:0]        pick_onehot;
   logic [WORD_W-1:0]           pick_offset;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         sdram_bank_match #(
            .WORD_W  (WORD_W),
            .BASE_LSB(BASE_LSB),
            .SIZE_LSB(SIZE_LSB),
            .SIZE_W  (SIZE_W),
            .MIN_LOG2(MIN_LOG2),
            .CFG_MASK(CFG_MASK)
         ) u_match (
            .en    (ctrl_en),
            .cfg   (bank_cfg[b*WORD_W +: WORD_W]),
            .addr  (addr),
            .match (match[b]),
            .offset(offsets[b*WORD_W +: WORD_W])
         );
      end
   endgenerate

   sdram_bank_pick #(
      .NUM_BANKS(NUM_BANKS),
      .WORD_W   (WORD_W)
   ) u_pick (
      .match  (match),
      .offsets(offsets),
      .any    (any),
      .idx    (pick_idx),
      .onehot (pick_onehot),
      .offset (pick_offset)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_vld    <= 1'b0;
         dec_hit    <= 1'b0;
         dec_miss   <= 1'b0;
         dec_bank   <= '0;
         dec_onehot <= '0;
         dec_offset <= '0;
      end else begin
         dec_vld    <= addr_vld;
         dec_hit    <= addr_vld && any;
         dec_miss   <= addr_vld && !any;
         dec_bank   <= addr_vld ? pick_idx : '0;
         dec_onehot <= addr_vld ? pick_onehot : '0;
         dec_offset <= addr_vld ? pick_offset : '0;
      end
   end
endmodule

// File: rtl/sdram_bank_decoder_chk.sv
module sdram_bank_decoder_chk
   import sdram_dec_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned WORD_W    = DEF_WORD_W,
   parameter int unsigned SIZE_LSB  = DEF_SIZE_LSB,
   parameter int unsigned SIZE_W    = DEF_SIZE_W,
   localparam int unsigned IDX_W    = idx_width(NUM_BANKS)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ctrl_en,
   input logic [NUM_BANKS*WORD_W-1:0] bank_cfg,
   input logic                        addr_vld,
   input logic                        dec_vld,
   input logic                        dec_hit,
   input logic                        dec_miss,
   input logic [IDX_W-1:0]            dec_bank,
   input logic [NUM_BANKS-1:0]        dec_onehot
);
   localparam int unsigned RSV = reserved_code(SIZE_W);

   a_r9_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
      addr_vld |=> dec_vld);
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_vld |=> (!dec_vld && !dec_hit && !dec_miss && dec_onehot == '0));
   a_r8_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> (dec_hit != dec_miss));
   a_r8_miss_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
      dec_miss |-> (dec_onehot == '0));
   a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dec_onehot));
   a_r7_idx_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> ($countones(dec_onehot) == 1 && dec_onehot[dec_bank]));
   a_r4_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && !ctrl_en) |=> dec_miss);

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
         a_r4_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (addr_vld && !bank_cfg[b*WORD_W]) |=> !dec_onehot[b]);
         a_r3_code7: assert property (@(posedge clk) disable iff (!rst_n)
            (addr_vld && 32'(bank_cfg[b*WORD_W + SIZE_LSB +: SIZE_W]) == RSV)
            |=> !dec_onehot[b]);
      end
   endgenerate
endmodule

bind sdram_bank_decoder sdram_bank_decoder_chk #(
   .NUM_BANKS(NUM_BANKS),
   .WORD_W   (WORD_W),
   .SIZE_LSB (SIZE_LSB),
   .SIZE_W   (SIZE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_en   (ctrl_en),
   .bank_cfg  (bank_cfg),
   .addr_vld  (addr_vld),
   .dec_vld   (dec_vld),
   .dec_hit   (dec_hit),
   .dec_miss  (dec_miss),
   .dec_bank  (dec_bank),
   .dec_onehot(dec_onehot)
);

// File: tb/test_sdram_bank_decoder.sv
`timescale 1ns/1ps
module test_sdram_bank_decoder;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctrl_en = 1'b0;
   logic [127:0]  bank_cfg = '0;
   logic          addr_vld = 1'b0;
   logic [31:0]   addr = '0;
   logic          dec_vld;
   logic          dec_hit;
   logic          dec_miss;
   logic [1:0]    dec_bank;
   logic [3:0]    dec_onehot;
   logic [31:0]   dec_offset;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   sdram_bank_decoder #(.NUM_BANKS(NB)) i_sdram_bank_decoder (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .bank_cfg(bank_cfg),
      .addr_vld(addr_vld), .addr(addr), .dec_vld(dec_vld), .dec_hit(dec_hit),
      .dec_miss(dec_miss), .dec_bank(dec_bank), .dec_onehot(dec_onehot),
      .dec_offset(dec_offset)
   );

   function automatic logic [31:0] mk(input logic [31:0] start, input int code, input bit v);
      return (start & 32'hFF80_0000) | (32'(code) << 17) | 32'(v);
   endfunction

   // expected result from the requirements: fields, span, range, priority
   function automatic logic [38:0] model(input logic [127:0] cfgs, input bit en,
                                         input logic [31:0] a);
      logic [63:0] st, sp;
      logic [31:0] w;
      int          code;
      logic [38:0] r;
      r = '0;
      for (int b = NB - 1; b >= 0; b--) begin
         w    = cfgs[b*32 +: 32];
         code = int'(w[19:17]);
         st   = {32'd0, w[31:23], 23'd0};
         sp   = 64'd4194304 << code;
         if (en && w[0] && code != 7 && {32'd0, a} >= st && {32'd0, a} < st + sp)
            r = {1'b1, 2'(b), 4'(1 << b), a - st[31:0]};
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   // one request per cycle: drive after a falling edge, sample at the next one
   task automatic probe(input logic [127:0] drive_cfg, input logic [127:0] ref_cfg,
                        input bit en, input logic [31:0] a, input string tag);
      logic [38:0] e;
      logic [39:0] act;
      logic [39:0] exp;
      bank_cfg = drive_cfg;
      ctrl_en  = en;
      addr     = a;
      addr_vld = 1'b1;
      @(negedge clk);
      e   = model(ref_cfg, en, a);
      act = {dec_vld, dec_hit, dec_miss, dec_bank, dec_onehot, dec_offset};
      exp = {1'b1, e[38], !e[38], e[37:36], e[35:32], e[31:0]};
      check(act == exp, tag, 64'(act), 64'(exp));
   endtask

   task automatic sweep(input logic [127:0] drive_cfg, input logic [127:0] ref_cfg,
                        input bit en, input string tag);
      logic [31:0] w, st, sp;
      for (int i = 0; i < 2048; i++)
         probe(drive_cfg, ref_cfg, en, (32'(i) << 21) | ((32'(i) * 32'h3B1) & 32'h1F_FFFF), tag);
      for (int b = 0; b < NB; b++) begin
         w  = ref_cfg[b*32 +: 32];
         st = {w[31:23], 23'd0};
         sp = 32'd4194304 << w[19:17];
         probe(drive_cfg, ref_cfg, en, st - 32'd1, tag);
         probe(drive_cfg, ref_cfg, en, st, tag);
         probe(drive_cfg, ref_cfg, en, st + sp - 32'd1, tag);
         probe(drive_cfg, ref_cfg, en, st + sp, tag);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired before the run completed");
         finish_run();
      end
   end

   initial begin
      logic [127:0] cfg_a, cfg_b, cfg_d, cfg_f, junk;
      cfg_a = {mk(32'h2000_0000, 1, 1), mk(32'h1800_0000, 0, 1),
               mk(32'h1000_0000, 5, 1), mk(32'h0000_0000, 6, 1)};
      cfg_b = cfg_a;
      cfg_b[32] = 1'b0;
      cfg_d = {mk(32'hFF80_0000, 6, 1), mk(32'h5000_0000, 7, 1),
               mk(32'h4000_0000, 6, 1), mk(32'h4000_0000, 4, 1)};
      cfg_f = {mk(32'h8080_0000, 2, 0), mk(32'h8000_0000, 3, 1),
               mk(32'h0180_0000, 1, 1), mk(32'h0180_0000, 0, 1)};
      junk  = {4{32'h0021_1FFE}};

      // R11: reset holds every output at zero
      repeat (3) @(negedge clk);
      check({dec_vld, dec_hit, dec_miss, dec_bank, dec_onehot, dec_offset} == '0,
            "R11 reset state", 64'({dec_vld, dec_hit, dec_miss, dec_bank, dec_onehot, dec_offset}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: an idle cycle yields no result
      addr_vld = 1'b0;
      ctrl_en  = 1'b1;
      bank_cfg = cfg_a;
      addr     = 32'h0000_1000;
      @(negedge clk);
      check({dec_vld, dec_hit, dec_miss, dec_onehot} == '0, "R9 idle cycle",
            64'({dec_vld, dec_hit, dec_miss, dec_onehot}), 64'd0);

      sweep(cfg_a, cfg_a, 1'b1, "R1 R2 R5 R6 R9 layout");
      sweep(cfg_b, cfg_b, 1'b1, "R4 bank valid bit");
      sweep(cfg_a, cfg_a, 1'b0, "R4 R8 global enable off");
      sweep(cfg_d, cfg_d, 1'b1, "R3 R5 R7 overlap, code 7, top of space");
      sweep(cfg_a | junk, cfg_a, 1'b1, "R10 masked-off bits");
      sweep(cfg_f, cfg_f, 1'b1, "R7 R2 small banks");

      // R9: qualifier dropping after a request
      addr_vld = 1'b0;
      @(negedge clk);
      check(!dec_vld && !dec_hit && !dec_miss, "R9 qualifier low",
            64'({dec_vld, dec_hit, dec_miss}), 64'd0);

      done = 1'b1;
      finish_run();
   end
endmodule